// File: doc/BRIEF.md
# Selectable Baud Clock Generator

This block makes the 16x-baud clock that drives an infrared serial encoder and decoder. In internal mode it divides a crystal clock (nominally 3.6864 MHz) by a ratio picked with a 3-bit rate code. Divide-by-2 gives 1.8432 MHz, which is 16 x 115200. One code passes the crystal through without division, for test use. In external mode the block forwards a 16x clock supplied from outside, and the internal path is unused.

Alongside the clock, the block gives a one-cycle enable in the crystal domain, for logic that prefers a clock enable to a derived clock. It also raises an oscillator power-down request. That request is high whenever the external source is chosen or an explicit power-down input is high.

The divider holds a counter that reloads once per output period. A new rate code is read only at a reload, so a code change never shortens or stretches the period that is running. Reset is asserted asynchronously and released through a short synchronizer in the crystal domain.

Top module: `baud_clk_gen`

## Requirements
- R1: While `rst_n` is low, `baud_clk_o` (internal source) and `baud_tick_o` are low. After `rst_n` rises, the first two rising crystal edges leave the outputs in that state, and the third edge starts the first output period.
- R2: In internal mode, with rate code values 0..6 giving divide ratios 2, 4, 12, 24, 6, 48, 96, each period lasts exactly that many crystal cycles. The output is low for the first half of the period and high for the second half.
- R3: Rate code 7 selects bypass. Once it takes effect, the internal clock equals the crystal clock, high in the crystal's high phase and low in its low phase.
- R4: The rate code is read only on the crystal edge that starts a new period. A change in the middle of a period leaves the current period's length and shape unchanged.
- R5: `baud_tick_o` is high for exactly one crystal cycle per period, following the edge where the divided clock rises. In bypass it is high on every cycle. It is low whenever the external source is selected.
- R6: When `src_ext` is high, `baud_clk_o` follows `ext_clk`. When it is low, `baud_clk_o` carries the internal clock.
- R7: `osc_pd_o` is high exactly when `src_ext` or `pd_req` is high.

Each period starts on a rising edge of `xtal_clk`, which the divider counts from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal clock; all registers run on its rising edge |
| ext_clk | input | 1 | Externally supplied 16x-baud clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| rate_sel | input | 3 | Rate code: 0..6 pick divide ratios 2,4,12,24,6,48,96; 7 is bypass |
| src_ext | input | 1 | 1 selects the external clock, 0 the internal divider |
| pd_req | input | 1 | Explicit oscillator power-down request |
| baud_clk_o | output | 1 | Selected 16x-baud clock |
| baud_tick_o | output | 1 | One-crystal-cycle enable marking each internal period |
| osc_pd_o | output | 1 | Oscillator power-down indication |

## Verification
The bench builds the block with its default counter width of 7 bits and a two-stage reset synchronizer. At these settings the largest ratio, 96, fits the counter with room to spare. The bench visits every rate code, including bypass, and changes the code in the middle of a long period to show that the change waits for the reload. It also runs the external source with a clock that is asynchronous to the crystal, so the output mux is observed as a pass-through rather than as something aligned to crystal edges.

// File: rtl/baud_clk_pkg.sv
package baud_clk_pkg;

  localparam int unsigned CNT_W  = 7;
  localparam int unsigned CODE_W = 3;

  typedef logic [CNT_W-1:0]  ratio_t;
  typedef logic [CODE_W-1:0] code_t;

  // Divide ratio per rate code; a ratio of 1 marks crystal pass-through.
  function automatic ratio_t code_to_ratio(input code_t code);
    ratio_t r;
    case (code)
      3'd0:    r = ratio_t'(2);
      3'd1:    r = ratio_t'(4);
      3'd2:    r = ratio_t'(12);
      3'd3:    r = ratio_t'(24);
      3'd4:    r = ratio_t'(6);
      3'd5:    r = ratio_t'(48);
      3'd6:    r = ratio_t'(96);
      default: r = ratio_t'(1);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/baud_rst_sync.sv
module baud_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/baud_divider.sv
module baud_divider
  import baud_clk_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic  clk,
  input  logic  rst_n,
  input  code_t rate_sel,
  output logic  div_clk,
  output logic  bypass,
  output logic  tick
);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] ratio_q, ratio_d;
  logic [W-1:0] half_d;
  logic         div_q, div_d;
  logic         byp_q, byp_d;
  logic         tick_q, tick_d;
  logic         reload;

  // next state
  always_comb begin
    reload  = (cnt_q == '0);
    ratio_d = reload ? W'(code_to_ratio(rate_sel)) : ratio_q;
    cnt_d   = reload ? ratio_d - W'(1) : cnt_q - W'(1);
    half_d  = ratio_d >> 1;
    byp_d   = (ratio_d == W'(1));
    div_d   = !byp_d && (cnt_d < half_d);
    tick_d  = byp_d || (cnt_d == half_d - W'(1));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= W'(2);
      div_q   <= 1'b0;
      byp_q   <= 1'b0;
      tick_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      div_q   <= div_d;
      byp_q   <= byp_d;
      tick_q  <= tick_d;
    end
  end

  assign div_clk = div_q;
  assign bypass  = byp_q;
  assign tick    = tick_q;

  // R4: the latched ratio only moves on a reload edge
  assert_ratio_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) != '0) |-> $stable(ratio_q));

  // R2: the counter never leaves the range of the current ratio
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);

  // R2: the first cycle of a divided period is in the low half
  assert_period_starts_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp_q && cnt_q == ratio_q - W'(1)) |-> !div_q);

  // R5: a tick outside bypass coincides with the rising edge of the divided clock
  assert_tick_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && !byp_q) |-> (div_q && !$past(div_q)));

endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen
  import baud_clk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_W       = CNT_W
) (
  input  logic       xtal_clk,
  input  logic       ext_clk,
  input  logic       rst_n,
  input  logic [2:0] rate_sel,
  input  logic       src_ext,
  input  logic       pd_req,
  output logic       baud_clk_o,
  output logic       baud_tick_o,
  output logic       osc_pd_o
);

  logic rst_n_int;
  logic div_clk;
  logic div_bypass;
  logic div_tick;
  logic int_clk;

  baud_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (xtal_clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  baud_divider #(.W(DIV_W)) u_div (
    .clk      (xtal_clk),
    .rst_n    (rst_n_int),
    .rate_sel (rate_sel),
    .div_clk  (div_clk),
    .bypass   (div_bypass),
    .tick     (div_tick)
  );

  assign int_clk     = div_bypass ? xtal_clk : div_clk;
  assign baud_clk_o  = src_ext ? ext_clk : int_clk;
  assign baud_tick_o = div_tick & ~src_ext;
  assign osc_pd_o    = src_ext | pd_req;

  // R1: the divider is held quiet while the synchronized reset is low
  assert_quiet_in_reset_R1: assert property (@(posedge xtal_clk)
    !rst_n_int |=> (!rst_n_int |-> (!div_clk && !div_tick)));

endmodule

// File: tb/baud_clk_gen_tb.sv
`timescale 1ns/1ps
module baud_clk_gen_tb;

  logic       xtal_clk = 1'b0;
  logic       ext_clk  = 1'b0;
  logic       rst_n;
  logic [2:0] rate_sel;
  logic       src_ext;
  logic       pd_req;
  logic       baud_clk_o, baud_tick_o, osc_pd_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_en = 0;

  always #5 xtal_clk = ~xtal_clk;
  initial begin
    #0.05;
    forever #7.1 ext_clk = ~ext_clk;
  end

  baud_clk_gen u_dut (
    .xtal_clk(xtal_clk), .ext_clk(ext_clk), .rst_n(rst_n),
    .rate_sel(rate_sel), .src_ext(src_ext), .pd_req(pd_req),
    .baud_clk_o(baud_clk_o), .baud_tick_o(baud_tick_o), .osc_pd_o(osc_pd_o)
  );

  function automatic int ratio_of(input logic [2:0] c);
    case (c)
      3'd0: return 2;   3'd1: return 4;   3'd2: return 12;
      3'd3: return 24;  3'd4: return 6;   3'd5: return 48;
      3'd6: return 96;  default: return 1;
    endcase
  endfunction

  // behavioural reference: position within the running period
  int edges_since_rel;
  int pos;
  int rcur;
  always @(posedge xtal_clk or negedge rst_n) begin
    if (!rst_n) begin
      edges_since_rel = 0; pos = -1; rcur = 2;
    end else if (edges_since_rel < 2) begin
      edges_since_rel++;
    end else if (pos < 0 || pos == rcur - 1) begin
      rcur = ratio_of(rate_sel); pos = 0;
    end else begin
      pos++;
    end
  end

  function automatic bit exp_byp();  return (pos >= 0) && (rcur == 1); endfunction
  function automatic bit exp_int();
    if (exp_byp()) return xtal_clk;
    return (pos >= 0) && (pos >= rcur / 2);
  endfunction
  function automatic bit exp_tick();
    if (src_ext || pos < 0) return 1'b0;
    return exp_byp() || (pos == rcur / 2);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // every-cycle comparison in the low phase of the crystal
  always @(negedge xtal_clk) begin
    cycles++;
    #1;
    if (cmp_en) begin
      check("R2 R3 R4 R6 clk",  baud_clk_o, src_ext ? ext_clk : exp_int());
      check("R5 tick", baud_tick_o, exp_tick());
      check("R7 pd",  osc_pd_o, src_ext | pd_req);
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge xtal_clk);
    #3;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rate_sel = 3'd0; src_ext = 1'b0; pd_req = 1'b0;
    wait_cyc(3);
    // R1: reset state
    check("R1 reset clk",  baud_clk_o, 1'b0);
    check("R1 reset tick", baud_tick_o, 1'b0);
    cmp_en = 1;
    rst_n = 1'b1;
    wait_cyc(2);
    check("R1 held after release", baud_clk_o, 1'b0);
    // R2: every divided rate, three periods each
    for (int c = 0; c < 7; c++) begin
      rate_sel = 3'(c);
      wait_cyc(3 * ratio_of(3'(c)) + 2);
    end
    // R3: bypass, high phase observed at mid-high
    rate_sel = 3'd7;
    wait_cyc(100);
    @(posedge xtal_clk); #2;
    check("R3 bypass high", baud_clk_o, 1'b1);
    wait_cyc(5);
    // R4: change mid-period of a long ratio
    rate_sel = 3'd3;
    wait_cyc(30);
    rate_sel = 3'd0;
    wait_cyc(3);
    check("R4 old period kept", baud_clk_o, exp_int());
    wait_cyc(30);
    // R7: power-down request alone
    pd_req = 1'b1;
    wait_cyc(10);
    check("R7 pd_req", osc_pd_o, 1'b1);
    pd_req = 1'b0;
    // R6, R5: external source
    src_ext = 1'b1;
    rate_sel = 3'd1;
    for (int i = 0; i < 40; i++) begin
      #2.3;
      check("R6 ext follow", baud_clk_o, ext_clk);
    end
    wait_cyc(20);
    check("R5 no tick ext", baud_tick_o, 1'b0);
    src_ext = 1'b0;
    wait_cyc(20);
    // R1: reset in the middle of operation
    rate_sel = 3'd5;
    wait_cyc(30);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", baud_clk_o, 1'b0);
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(110);
    finish_run();
  end

endmodule